// File: doc/BRIEF.md
# Reference Clock Pre-Divider to 8 kHz

This block stands in front of a phase comparator. It takes three reference clock levels that have already been synchronized, picks one of them, and emits a one-cycle comparison strobe. With division off, it emits one strobe for each rising edge of the chosen reference. With division on, it counts rising edges and emits one strobe per 8 kHz period.

Each reference has its own settings: a 4-bit spot-frequency code, a divide-enable bit and a multiplier field for N x 8 kHz inputs. A network-mode input decides what the shared 1.544/2.048 MHz code means. A further input chooses which edge of the divided waveform the strobe marks. Any change to the active settings restarts the count.

The block runs on one sampling clock. That clock must be at least twice as fast as any reference.

Top module: `refdiv8k`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cmpStrobe` is 0.
- R2: `refSel` values 0 to 2 choose `refIn[refSel]`; the value 3 chooses no reference and never produces a strobe. The other references have no effect on the output.
- R3: With the chosen reference's `refLock` bit at 0, each rising edge of that reference gives exactly one strobe. The strobe comes two clock edges after the sampled input rises.
- R4: With `refLock` at 1, the divide ratio comes from the 4-bit code: 5 gives 810, 6 gives 2430, 7 gives 3240, 8 gives 4860, 9 gives 6480, 10 gives 9720 and 11 gives 19440. Codes 0, 1 and 2 (2, 4 and 8 kHz) give 1.
- R5: Code 4 gives a ratio of 193 when `sonetMode` is 1 and 256 when it is 0.
- R6: Code 3 takes its ratio from that reference's 8-bit `refMult` field; a field value of 0 acts as 1.
- R7: Rising edges are numbered from 1 after each restart. With `edgeFall` at 0, a strobe follows edge k*ratio. With `edgeFall` at 1, a strobe follows edge floor(ratio/2)+1+k*ratio.
- R8: A change to `refSel`, `sonetMode`, `edgeFall`, or to the chosen reference's code, lock bit or multiplier restarts the count. No strobe follows the clock edge at which the change is sampled, and a reference edge in that cycle is not counted.
- R9: `cmpStrobe` is never high in two consecutive cycles.
- R10: Codes 12 to 15 act as a ratio of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 3 | Synchronized reference levels |
| refSel | input | 2 | Chosen reference; 3 means none |
| refCode | input | 12 | Spot-frequency code, 4 bits per reference |
| refLock | input | 3 | Divide-to-8 kHz enable, one bit per reference |
| refMult | input | 24 | N for N x 8 kHz, 8 bits per reference |
| sonetMode | input | 1 | 1 selects SONET, 0 selects SDH |
| edgeFall | input | 1 | 1 aligns the strobe to the falling edge of the divided wave |
| cmpStrobe | output | 1 | One-cycle comparison strobe |

## Verification
Some properties are checked by assertions on every cycle. These are: the strobe is a single pulse, the counter stays below the active ratio, a restart clears the counter and holds back the strobe, an undivided edge always fires, and an empty selection never steps the counter. Other behaviour can only be shown by the bench's scenarios, run against a behavioural model. This covers the ratio for every code, the code that depends on the mode, the N multiplier and its zero case, the offset of the falling-edge alignment, and the fact that unselected references are ignored.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef struct packed {
    logic clear;  // restart counting, suppress strobe
    logic step;   // one counted reference rising edge
  } pdivCtlT;

  localparam logic [3:0] CODE_NX8K   = 4'd3;
  localparam logic [3:0] CODE_T1E1   = 4'd4;

  // Edges of the reference per 8 kHz period.
  function automatic int spotRatio(input logic [3:0] code, input logic sonet, input int nMul);
    case (code)
      4'd0, 4'd1, 4'd2: return 1;
      CODE_NX8K:        return (nMul == 0) ? 1 : nMul;
      CODE_T1E1:        return sonet ? 193 : 256;
      4'd5:             return 810;
      4'd6:             return 2430;
      4'd7:             return 3240;
      4'd8:             return 4860;
      4'd9:             return 6480;
      4'd10:            return 9720;
      4'd11:            return 19440;
      default:          return 1;
    endcase
  endfunction

endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int NREF    = 3,
  parameter int SEL_W   = 2,
  parameter int CODE_W  = 4,
  parameter int N_W     = 8,
  parameter int RATIO_W = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREF-1:0]        refIn,
  input  logic [SEL_W-1:0]       refSel,
  input  logic [NREF*CODE_W-1:0] refCode,
  input  logic [NREF-1:0]        refLock,
  input  logic [NREF*N_W-1:0]    refMult,
  input  logic                   sonetMode,
  input  logic                   edgeFall,
  output pdivCtlT                ctl,
  output logic [RATIO_W-1:0]     ratio,
  output logic                   lockEn,
  output logic                   fallSel
);

  localparam int KEY_W = SEL_W + CODE_W + 1 + N_W + 2;

  logic              selLvl;
  logic [CODE_W-1:0] selCode;
  logic              selLock;
  logic [N_W-1:0]    selMult;
  logic [KEY_W-1:0]  cfgKey, keyReg;
  logic              keyValid, changed;
  logic              refCur, refPrev;

  always_comb begin
    selLvl  = 1'b0;
    selCode = '0;
    selLock = 1'b0;
    selMult = '0;
    for (int i = 0; i < NREF; i++) begin
      if (refSel == SEL_W'(i)) begin
        selLvl  = refIn[i];
        selCode = refCode[i*CODE_W +: CODE_W];
        selLock = refLock[i];
        selMult = refMult[i*N_W +: N_W];
      end
    end
  end

  assign cfgKey  = {refSel, selCode, selLock, selMult, sonetMode, edgeFall};
  assign changed = !keyValid || (cfgKey != keyReg);

  always_ff @(posedge clk) begin
    if (rst) begin
      keyValid <= 1'b0;
      keyReg   <= '0;
      refCur   <= 1'b0;
      refPrev  <= 1'b0;
    end else begin
      keyValid <= 1'b1;
      keyReg   <= cfgKey;
      if (changed) begin
        refCur  <= selLvl;
        refPrev <= selLvl;
      end else begin
        refPrev <= refCur;
        refCur  <= selLvl;
      end
    end
  end

  assign ctl.clear = changed;
  assign ctl.step  = !changed && refCur && !refPrev;
  assign ratio     = RATIO_W'(spotRatio(selCode, sonetMode, int'(selMult)));
  assign lockEn    = selLock;
  assign fallSel   = edgeFall;

  // R2
  idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (refSel >= SEL_W'(NREF) && $past(refSel >= SEL_W'(NREF)) && !ctl.clear) |-> !ctl.step);

endmodule

// File: rtl/refdiv_dp.sv
module refdiv_dp
  import refdiv_pkg::*;
#(
  parameter int RATIO_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  pdivCtlT            ctl,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               lockEn,
  input  logic               fallSel,
  output logic               strobe
);

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] lastCnt, halfCnt;
  logic               atLast, hit;

  assign lastCnt = ratio - RATIO_W'(1);
  assign halfCnt = ratio >> 1;
  assign atLast  = (cnt == lastCnt);
  assign hit     = !lockEn || (fallSel ? (cnt == halfCnt) : atLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= ctl.step && hit;
      if (ctl.clear)
        cnt <= '0;
      else if (ctl.step && lockEn)
        cnt <= atLast ? '0 : cnt + RATIO_W'(1);
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) strobe |=> !strobe);
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) !ctl.clear |-> (cnt < ratio));
  // R8
  clear_quiet_chk: assert property (@(posedge clk) disable iff (rst) ctl.clear |=> (!strobe && cnt == '0));
  // R3
  passthru_fire_chk: assert property (@(posedge clk) disable iff (rst) (ctl.step && !lockEn) |=> strobe);

endmodule

// File: rtl/refdiv8k.sv
module refdiv8k
  import refdiv_pkg::*;
#(
  parameter int NREF    = 3,
  parameter int SEL_W   = 2,
  parameter int CODE_W  = 4,
  parameter int N_W     = 8,
  parameter int RATIO_W = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREF-1:0]        refIn,
  input  logic [SEL_W-1:0]       refSel,
  input  logic [NREF*CODE_W-1:0] refCode,
  input  logic [NREF-1:0]        refLock,
  input  logic [NREF*N_W-1:0]    refMult,
  input  logic                   sonetMode,
  input  logic                   edgeFall,
  output logic                   cmpStrobe
);

  pdivCtlT            ctl;
  logic [RATIO_W-1:0] ratio;
  logic               lockEn, fallSel;

  refdiv_ctrl #(.NREF(NREF), .SEL_W(SEL_W), .CODE_W(CODE_W), .N_W(N_W), .RATIO_W(RATIO_W)) uCtrl (
    .clk(clk), .rst(rst), .refIn(refIn), .refSel(refSel), .refCode(refCode),
    .refLock(refLock), .refMult(refMult), .sonetMode(sonetMode), .edgeFall(edgeFall),
    .ctl(ctl), .ratio(ratio), .lockEn(lockEn), .fallSel(fallSel)
  );

  refdiv_dp #(.RATIO_W(RATIO_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .ratio(ratio), .lockEn(lockEn),
    .fallSel(fallSel), .strobe(cmpStrobe)
  );

endmodule

// File: tb/refdiv8k_test.sv
module refdiv8k_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  refIn = '0;
  logic [1:0]  refSel = '0;
  logic [11:0] refCode = '0;
  logic [2:0]  refLock = '0;
  logic [23:0] refMult = '0;
  logic        sonetMode = 1'b1;
  logic        edgeFall = 1'b0;
  logic        cmpStrobe;

  int checks = 0, errors = 0, cyc = 0, hits = 0;
  bit modelOn = 0, lastStrobe = 0, done = 0;
  string curReq = "R3";

  always #5 clk = ~clk;

  refdiv8k uut (.clk(clk), .rst(rst), .refIn(refIn), .refSel(refSel), .refCode(refCode),
    .refLock(refLock), .refMult(refMult), .sonetMode(sonetMode), .edgeFall(edgeFall),
    .cmpStrobe(cmpStrobe));

  // free-running references: ref i toggles every i+1 cycles
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 3; i++)
      if (cyc % (i + 1) == 0) refIn[i] <= ~refIn[i];
  end

  function automatic int modelRatio(int code, bit sonet, int n);
    int khz;
    case (code)
      0: khz = 2;  1: khz = 4;  2: khz = 8;
      3: return (n == 0) ? 1 : n;
      4: khz = sonet ? 1544 : 2048;
      5: khz = 6480;   6: khz = 19440;  7: khz = 25920;
      8: khz = 38880;  9: khz = 51840;  10: khz = 77760;
      11: khz = 155520;
      default: khz = 8;
    endcase
    return (khz < 8) ? 1 : khz / 8;
  endfunction

  // behavioural reference model
  bit expStrobe = 0, keyOk = 0, lvlA = 0, lvlB = 0;
  int edgeNum = 0;
  int pSel, pCode, pLock, pMult, pMode, pFall;
  always @(posedge clk) begin
    int s, c, l, n, r, off;
    bit lvl, fresh;
    if (rst) begin
      keyOk = 0; expStrobe = 0; lvlA = 0; lvlB = 0; edgeNum = 0;
    end else begin
      s = refSel;
      c = (s < 3) ? refCode[s*4 +: 4] : 0;
      l = (s < 3) ? refLock[s] : 0;
      n = (s < 3) ? refMult[s*8 +: 8] : 0;
      lvl = (s < 3) ? refIn[s] : 1'b0;
      fresh = !keyOk || s != pSel || c != pCode || l != pLock || n != pMult ||
              pMode != sonetMode || pFall != edgeFall;
      if (fresh) begin
        expStrobe = 0; edgeNum = 0; lvlA = lvl; lvlB = lvl; keyOk = 1;
        pSel = s; pCode = c; pLock = l; pMult = n; pMode = sonetMode; pFall = edgeFall;
      end else begin
        expStrobe = 0;
        if (lvlA && !lvlB) begin
          if (l == 0) expStrobe = 1;
          else begin
            edgeNum++;
            r = modelRatio(c, sonetMode, n);
            off = edgeFall ? r / 2 + 1 : r;
            expStrobe = (edgeNum >= off) && ((edgeNum - off) % r == 0);
          end
        end
        lvlB = lvlA; lvlA = lvl;
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && !rst) begin
      checks++;
      if (cmpStrobe !== expStrobe) begin
        errors++;
        $display("FAIL %s cycle %0d strobe got %b exp %b", curReq, cyc, cmpStrobe, expStrobe);
      end
      if (lastStrobe && cmpStrobe) begin
        checks++; errors++;
        $display("FAIL R9 cycle %0d strobe got 1 exp 0 (back-to-back)", cyc);
      end
      if (cmpStrobe) hits++;
      lastStrobe = cmpStrobe;
    end
  end

  task automatic setRef(int s, int code, bit lock, int n, bit mode, bit fall);
    @(negedge clk);
    refSel = 2'(s);
    if (s < 3) begin
      refCode[s*4 +: 4] = 4'(code);
      refLock[s] = lock;
      refMult[s*8 +: 8] = 8'(n);
    end
    sonetMode = mode;
    edgeFall = fall;
    hits = 0;
  endtask

  task automatic expectHits(string req, int want);
    checks++;
    if (hits != want) begin
      errors++;
      $display("FAIL %s strobe count got %0d exp %0d", req, hits, want);
    end
  endtask

  initial begin
    // R1: reset holds strobe low
    repeat (3) @(negedge clk);
    checks++;
    if (cmpStrobe !== 1'b0) begin
      errors++;
      $display("FAIL R1 strobe in reset got %b exp 0", cmpStrobe);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (cmpStrobe !== 1'b0) begin
      errors++;
      $display("FAIL R1 strobe after reset got %b exp 0", cmpStrobe);
    end
    modelOn = 1;

    // R3: pass-through, ref0 edges every 2 cycles
    curReq = "R3";
    setRef(0, 6, 0, 0, 1, 0);
    repeat (40) @(negedge clk);
    checks++;
    if (hits < 18 || hits > 20) begin
      errors++;
      $display("FAIL R3 pass-through strobes got %0d exp 18..20", hits);
    end

    // R2: ref1 chosen, edges every 4 cycles; then no reference
    curReq = "R2";
    refLock[0] = 1'b1; // other references' settings must not matter
    setRef(1, 0, 0, 0, 1, 0);
    repeat (40) @(negedge clk);
    checks++;
    if (hits < 9 || hits > 10) begin
      errors++;
      $display("FAIL R2 ref1 strobes got %0d exp 9..10", hits);
    end
    setRef(3, 0, 0, 0, 1, 0);
    repeat (40) @(negedge clk);
    expectHits("R2", 0);

    // R6: N x 8 kHz, N = 5 and N = 0
    curReq = "R6";
    setRef(0, 3, 1, 5, 1, 0);
    repeat (54) @(negedge clk);
    expectHits("R6", 5);
    setRef(0, 3, 1, 0, 1, 0);
    repeat (20) @(negedge clk);
    checks++;
    if (hits < 8) begin
      errors++;
      $display("FAIL R6 N=0 strobes got %0d exp >=8", hits);
    end

    // R10: reserved code behaves as ratio 1
    curReq = "R10";
    setRef(0, 13, 1, 0, 1, 0);
    repeat (20) @(negedge clk);
    checks++;
    if (hits < 8) begin
      errors++;
      $display("FAIL R10 reserved code strobes got %0d exp >=8", hits);
    end

    // R8: change multiplier mid-count; the model tracks the restart
    curReq = "R8";
    setRef(0, 3, 1, 7, 1, 0);
    repeat (9) @(negedge clk);
    setRef(0, 3, 1, 6, 1, 0);
    checks++;
    if (cmpStrobe !== 1'b0) begin
      errors++;
      $display("FAIL R8 strobe at change got %b exp 0", cmpStrobe);
    end
    repeat (30) @(negedge clk);

    // R7: falling alignment, small ratio
    curReq = "R7";
    setRef(0, 3, 1, 6, 1, 1);
    repeat (34) @(negedge clk);
    expectHits("R7", 3);

    // R5 and R4: large codes, SONET rising, one strobe per run
    for (int code = 4; code <= 11; code++) begin
      int r;
      curReq = (code == 4) ? "R5" : "R4";
      r = modelRatio(code, 1, 0);
      setRef(0, code, 1, 0, 1, 0);
      repeat (2 * r + 6) @(negedge clk);
      expectHits(curReq, 1);
    end
    // SDH, falling alignment
    for (int code = 4; code <= 11; code++) begin
      int r;
      curReq = (code == 4) ? "R5" : "R7";
      r = modelRatio(code, 0, 0);
      setRef(0, code, 1, 0, 0, 1);
      repeat (r + 6) @(negedge clk);
      expectHits(curReq, 1);
    end

    modelOn = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule